// File: doc/BRIEF.md
# Serial-Word DAC Control Front End

This block is the digital side of a 12-bit voltage-output converter with a serial input. It watches four slow serial pins: a bit clock, a data line, a frame strobe and an active-low select. It samples them into the system clock with a chain of synchronising flops and finds their edges there. A frame opens when the frame strobe falls while the select is low. One bit is taken on each falling edge of the bit clock, most significant bit first. The frame closes after sixteen bits, or earlier when the strobe rises.

A closed frame holds a 16-bit word. Its top bit and bit 12 together form a two-bit address. The two bits between them carry a speed bit and a power-down bit. The low twelve bits carry a value. Depending on the address, the value goes into the converter code register or into the reference-selection control register, or the word is dropped. The block presents the held code, the chosen reference mode, the settling-speed mode and the power-down flag to the analogue macro.

Top module: `dacfe_top`

## Requirements
- R1: After reset, `code_o` is 0, `ref_mode_o` is 2'b00 (external), `fast_o` is 0 and `pwrdn_o` is 0.
- R2: A frame starts only on a falling edge of `fsync_i` seen while `sel_n_i` is low. A falling edge seen while `sel_n_i` is high starts nothing, even if `sel_n_i` goes low later with `fsync_i` still low.
- R3: Inside a frame, each falling edge of `bclk_i` shifts in `sdata_i`, most significant bit first. The 16th bit closes the frame and commits the word.
- R4: A rising edge of `fsync_i` after 1 to 15 bits commits the partial word. The received bits sit right-aligned and the upper bits are zero. A rising edge with no bits received commits nothing.
- R5: The address is {bit 15, bit 12}. Address 2'b00 loads bits 11:0 into `code_o`. Addresses 2'b00 and 2'b11 both load bit 14 into `fast_o` (1 = fast settling) and bit 13 into `pwrdn_o` (1 = powered down).
- R6: Addresses 2'b01 and 2'b10 are reserved. A word with either address changes none of the outputs.
- R7: Address 2'b11 loads the reference mode from bits 1:0 and leaves `code_o` unchanged. Bits 01 select `ref_mode_o` = 01 (low internal reference). Bits 10 select 10 (high internal reference). Bits 00 and 11 select 00 (external). `ref_mode_o` is never 2'b11.
- R8: Entering or leaving power-down through a control word leaves `code_o` at the code written before.
- R9: `sel_n_i` going high inside a frame drops the partial word. No output changes, whatever bit clocks or strobe edges follow before the next frame start.
- R10: Falling edges of `bclk_i` outside a frame change nothing.
- R11: The outputs change exactly SYNC_STAGES+2 system clock cycles after the pin edge that closes the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock; data is taken on its falling edge |
| sdata_i | input | 1 | Serial data, MSB first |
| fsync_i | input | 1 | Frame strobe; its fall opens a frame and its rise may close one |
| sel_n_i | input | 1 | Active-low select; high blocks frames and aborts an open one |
| code_o | output | 12 | Held converter code |
| ref_mode_o | output | 2 | 00 external, 01 low internal, 10 high internal reference |
| fast_o | output | 1 | 1 selects fast settling, 0 slow |
| pwrdn_o | output | 1 | 1 requests power-down |

## Verification
The assertions hold several rules on every cycle. The bit count never passes the word length. A commit always leaves the frame closed. Raising the select inside a frame closes it without a commit. No commit happens while no frame is open. A reserved address freezes every output. The code register moves only on a data-address commit. The reference mode never takes the value 11. The bench's scenarios show what no single-cycle property can: the order in which bits arrive, the right alignment of a word cut short by the strobe, and the code returning after power-down. They also show that a strobe fall under a high select is ignored and that the commit latency is exact. A behavioural model in the bench is compared with all outputs on every clock.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

   typedef enum logic [1:0] {
      ADDR_CODE  = 2'b00,
      ADDR_RSV_A = 2'b01,
      ADDR_RSV_B = 2'b10,
      ADDR_CTRL  = 2'b11
   } addr_e;

   typedef enum logic [1:0] {
      REF_EXT    = 2'b00,
      REF_INT_LO = 2'b01,
      REF_INT_HI = 2'b10
   } ref_mode_e;

   function automatic ref_mode_e decode_ref(input logic [1:0] field);
      case (field)
         2'b01:   return REF_INT_LO;
         2'b10:   return REF_INT_HI;
         default: return REF_EXT;
      endcase
   endfunction

endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
   parameter int               WIDTH   = 4,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("dacfe_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q[s] <= RST_VAL;
         end else if (s == 0) begin
            chain_q[s] <= async_i;
         end else begin
            chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/dacfe_framer.sv
module dacfe_framer #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bclk_s,
   input  logic              sdata_s,
   input  logic              fsync_s,
   input  logic              sel_n_s,
   output logic              commit_o,
   output logic [WORD_W-1:0] word_o
);

   localparam int               CNT_W    = $clog2(WORD_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

   if (WORD_W < 5) begin : g_bad_word
      $error("dacfe_framer: WORD_W must hold four control bits and data");
   end

   logic              bclk_d, fsync_d;
   logic              bclk_fall, fs_fall, fs_rise;
   logic              active_q;
   logic [CNT_W-1:0]  cnt_q, cnt_n;
   logic [WORD_W-1:0] sh_q, sh_n;
   logic              commit_q;
   logic [WORD_W-1:0] word_q;
   logic              done_full, done_early;

   assign bclk_fall = bclk_d & ~bclk_s;
   assign fs_fall   = fsync_d & ~fsync_s;
   assign fs_rise   = ~fsync_d & fsync_s;

   always_comb begin
      sh_n  = sh_q;
      cnt_n = cnt_q;
      if (bclk_fall) begin
         sh_n  = {sh_q[WORD_W-2:0], sdata_s};
         cnt_n = cnt_q + 1'b1;
      end
      done_full  = (cnt_n == CNT_FULL);
      done_early = fs_rise && (cnt_n != '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_d   <= 1'b1;
         fsync_d  <= 1'b1;
         active_q <= 1'b0;
         cnt_q    <= '0;
         sh_q     <= '0;
         commit_q <= 1'b0;
         word_q   <= '0;
      end else begin
         bclk_d   <= bclk_s;
         fsync_d  <= fsync_s;
         commit_q <= 1'b0;
         if (sel_n_s) begin
            active_q <= 1'b0;
         end else if (fs_fall) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
            sh_q     <= '0;
         end else if (active_q) begin
            sh_q  <= sh_n;
            cnt_q <= cnt_n;
            if (done_full || done_early) begin
               commit_q <= 1'b1;
               word_q   <= sh_n;
               active_q <= 1'b0;
            end else if (fs_rise) begin
               active_q <= 1'b0;
            end
         end
      end
   end

   assign commit_o = commit_q;
   assign word_o   = word_q;

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_FULL);  // R3
   AST_COMMIT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      commit_q |-> !active_q);  // R4
   AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && sel_n_s) |=> (!active_q && !commit_q));  // R9
   AST_IDLE_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      !active_q |=> !commit_q);  // R10

endmodule

// File: rtl/dacfe_regs.sv
module dacfe_regs
   import dacfe_pkg::*;
#(
   parameter int DATA_W = 12,
   localparam int WORD_W = DATA_W + 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit_i,
   input  logic [WORD_W-1:0] word_i,
   output logic [DATA_W-1:0] code_o,
   output logic [1:0]        ref_mode_o,
   output logic              fast_o,
   output logic              pwrdn_o
);

   if (DATA_W < 2) begin : g_bad_data
      $error("dacfe_regs: DATA_W must hold the two reference bits");
   end

   addr_e             addr;
   logic [DATA_W-1:0] code_q;
   ref_mode_e         ref_q;
   logic              fast_q, pwrdn_q;

   assign addr = addr_e'({word_i[WORD_W-1], word_i[WORD_W-4]});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q  <= '0;
         ref_q   <= REF_EXT;
         fast_q  <= 1'b0;
         pwrdn_q <= 1'b0;
      end else if (commit_i) begin
         case (addr)
            ADDR_CODE: begin
               code_q  <= word_i[DATA_W-1:0];
               fast_q  <= word_i[WORD_W-2];
               pwrdn_q <= word_i[WORD_W-3];
            end
            ADDR_CTRL: begin
               ref_q   <= decode_ref(word_i[1:0]);
               fast_q  <= word_i[WORD_W-2];
               pwrdn_q <= word_i[WORD_W-3];
            end
            default: ;
         endcase
      end
   end

   assign code_o     = code_q;
   assign ref_mode_o = ref_q;
   assign fast_o     = fast_q;
   assign pwrdn_o    = pwrdn_q;

   AST_RSVD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_i && (addr == ADDR_RSV_A || addr == ADDR_RSV_B)) |=>
      ($stable(code_q) && $stable(ref_q) && $stable(fast_q) && $stable(pwrdn_q)));  // R6
   AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(commit_i && addr == ADDR_CODE) |=> $stable(code_q));  // R8
   AST_REF_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      ref_q != 2'b11);  // R7

endmodule

// File: rtl/dacfe_top.sv
module dacfe_top #(
   parameter int DATA_W      = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bclk_i,
   input  logic              sdata_i,
   input  logic              fsync_i,
   input  logic              sel_n_i,
   output logic [DATA_W-1:0] code_o,
   output logic [1:0]        ref_mode_o,
   output logic              fast_o,
   output logic              pwrdn_o
);

   localparam int WORD_W = DATA_W + 4;

   logic              bclk_s, sdata_s, fsync_s, sel_n_s;
   logic              commit;
   logic [WORD_W-1:0] word;

   dacfe_sync #(
      .WIDTH   (4),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (4'b1110)
   ) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({sel_n_i, fsync_i, bclk_i, sdata_i}),
      .sync_o  ({sel_n_s, fsync_s, bclk_s, sdata_s})
   );

   dacfe_framer #(
      .WORD_W (WORD_W)
   ) i_framer (
      .clk      (clk),
      .rst_n    (rst_n),
      .bclk_s   (bclk_s),
      .sdata_s  (sdata_s),
      .fsync_s  (fsync_s),
      .sel_n_s  (sel_n_s),
      .commit_o (commit),
      .word_o   (word)
   );

   dacfe_regs #(
      .DATA_W (DATA_W)
   ) i_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .commit_i   (commit),
      .word_i     (word),
      .code_o     (code_o),
      .ref_mode_o (ref_mode_o),
      .fast_o     (fast_o),
      .pwrdn_o    (pwrdn_o)
   );

endmodule

// File: tb/test_dacfe_top.sv
module test_dacfe_top;

   localparam int CLK_P = 10;
   localparam int SYNC  = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bclk = 1'b1, sdata = 1'b0, fsync = 1'b1, sel_n = 1'b1;
   logic [11:0] code;
   logic [1:0]  ref_mode;
   logic        fast, pwrdn;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   dacfe_top #(.DATA_W(12), .SYNC_STAGES(SYNC)) i_dacfe_top (
      .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .sdata_i(sdata),
      .fsync_i(fsync), .sel_n_i(sel_n), .code_o(code),
      .ref_mode_o(ref_mode), .fast_o(fast), .pwrdn_o(pwrdn)
   );

   // behavioural reference model: pin history delayed by the sampling depth
   logic [3:0]  hq[$];
   bit          m_act, m_pend, m_fast, m_pd;
   int          m_cnt;
   logic [15:0] m_sh, m_pw;
   logic [11:0] m_code;
   logic [1:0]  m_ref;

   always @(posedge clk or negedge rst_n) begin : model
      logic [3:0] cur, prv;
      if (!rst_n) begin
         hq.delete();
         for (int i = 0; i < SYNC + 1; i++) hq.push_back(4'b1110);
         m_act = 0; m_pend = 0; m_cnt = 0; m_sh = '0; m_pw = '0;
         m_code = '0; m_ref = 2'b00; m_fast = 0; m_pd = 0;
      end else begin
         if (m_pend) begin
            if (m_pw[15] == m_pw[12]) begin
               m_fast = m_pw[14];
               m_pd   = m_pw[13];
               if (!m_pw[15]) m_code = m_pw[11:0];
               else m_ref = (m_pw[1:0] == 2'b01) ? 2'b01 :
                            (m_pw[1:0] == 2'b10) ? 2'b10 : 2'b00;
            end
         end
         m_pend = 0;
         hq.push_back({sel_n, fsync, bclk, sdata});
         cur = hq[hq.size()-1-SYNC];
         prv = hq[hq.size()-2-SYNC];
         void'(hq.pop_front());
         if (cur[3]) m_act = 0;
         else if (prv[2] && !cur[2]) begin
            m_act = 1; m_cnt = 0; m_sh = '0;
         end else if (m_act) begin
            if (prv[1] && !cur[1]) begin
               m_sh = {m_sh[14:0], cur[0]};
               m_cnt++;
            end
            if (m_cnt == 16 || (!prv[2] && cur[2] && m_cnt > 0)) begin
               m_pend = 1; m_pw = m_sh; m_act = 0;
            end else if (!prv[2] && cur[2]) m_act = 0;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if ({code, ref_mode, fast, pwrdn} !== {m_code, m_ref, m_fast, m_pd}) begin
            fails++;
            $display("FAIL R11 per-cycle model: actual=%h/%b/%b/%b expected=%h/%b/%b/%b",
                     code, ref_mode, fast, pwrdn, m_code, m_ref, m_fast, m_pd);
         end
      end
   end

   task automatic chk(input string req, input [31:0] act, input [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_all(input string req, input [11:0] c, input [1:0] r,
                          input bit f, input bit p);
      chk({req, " code"}, 32'(code), 32'(c));
      chk({req, " ref"},  32'(ref_mode), 32'(r));
      chk({req, " fast"}, 32'(fast), 32'(f));
      chk({req, " pwrdn"}, 32'(pwrdn), 32'(p));
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic frame_open();
      sel_n = 1'b0; wait_n(3);
      fsync = 1'b0; wait_n(4);
   endtask

   task automatic clock_bits(input logic [15:0] w, input int n);
      for (int i = 0; i < n; i++) begin
         sdata = w[n-1-i]; wait_n(3);
         bclk = 1'b0;      wait_n(4);
         bclk = 1'b1;      wait_n(3);
      end
   endtask

   task automatic frame_close();
      fsync = 1'b1; wait_n(3);
      sel_n = 1'b1; wait_n(12);
   endtask

   task automatic send_word(input logic [15:0] w);
      frame_open();
      clock_bits(w, 16);
      frame_close();
   endtask

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL R11 watchdog actual=running expected=finished");
         report();
      end
   end

   initial begin : stim
      int lat;
      wait_n(5);
      rst_n = 1'b1;
      wait_n(2);
      chk_all("R1 reset", 12'h000, 2'b00, 0, 0);

      send_word(16'h4ABC);
      chk_all("R3 R5 data write", 12'hABC, 2'b00, 1, 0);
      send_word(16'h0801);
      chk_all("R3 msb-first order", 12'h801, 2'b00, 0, 0);
      send_word(16'h4ABC);

      send_word(16'h9002);
      chk_all("R7 ref high", 12'hABC, 2'b10, 0, 0);
      send_word(16'h9003);
      chk_all("R7 ref 11 -> external", 12'hABC, 2'b00, 0, 0);
      send_word(16'h9001);
      chk_all("R7 ref low", 12'hABC, 2'b01, 0, 0);

      send_word(16'h7FFF);
      chk_all("R6 reserved 01", 12'hABC, 2'b01, 0, 0);
      send_word(16'hEFFF);
      chk_all("R6 reserved 10", 12'hABC, 2'b01, 0, 0);

      send_word(16'hB001);
      chk_all("R8 power down", 12'hABC, 2'b01, 0, 1);
      send_word(16'h9001);
      chk_all("R8 wake keeps code", 12'hABC, 2'b01, 0, 0);

      frame_open(); clock_bits(16'h005A, 8); frame_close();
      chk_all("R4 early end", 12'h05A, 2'b01, 0, 0);
      frame_open(); frame_close();
      chk_all("R4 no bits", 12'h05A, 2'b01, 0, 0);

      frame_open(); clock_bits(16'h0777, 10);
      sel_n = 1'b1; wait_n(4);
      clock_bits(16'h003F, 6);
      frame_close();
      chk_all("R9 abort", 12'h05A, 2'b01, 0, 0);

      sel_n = 1'b0; wait_n(3);
      clock_bits(16'hFFFF, 16);
      sel_n = 1'b1; wait_n(12);
      chk_all("R10 clocks outside frame", 12'h05A, 2'b01, 0, 0);

      fsync = 1'b0; wait_n(4);
      sel_n = 1'b0; wait_n(4);
      clock_bits(16'h0123, 16);
      frame_close();
      chk_all("R2 fall under high select", 12'h05A, 2'b01, 0, 0);

      frame_open();
      clock_bits(16'h0321 >> 1, 15);
      sdata = 1'b1; wait_n(3);
      bclk = 1'b0;
      lat = 0;
      while (code !== 12'h321 && lat < 20) begin
         @(negedge clk);
         lat++;
      end
      chk("R11 commit latency", 32'(lat), 32'(SYNC + 2));
      bclk = 1'b1; wait_n(3);
      frame_close();
      chk_all("R3 R11 final word", 12'h321, 2'b01, 0, 0);

      done = 1'b1;
      report();
   end

endmodule